// File: doc/BRIEF.md
# Time-Multiplexed STDP Weight Adaptor

This block applies a spike-timing weight rule to many virtual synapses that share one physical adaptor. Every clock cycle in which `slot_vld` is high, the block serves one slot: it takes that slot's aligned pre-synaptic and post-synaptic spike flags, plus the state of the shared time window (the active bit and, when a digital timer drives it, its count). It looks up the slot's 4-bit weight in a local cache and a polarity bit that records which spike type opened the window. From these it decides whether to open or restart the window or to move the weight up or down.

Master memory keeps only one bistable bit per synapse. When the controller loads a slot, the cache gets that bit as the weight's MSB, and the three low bits come from a free-running LFSR. Each time a weight actually changes, it is binarised against a pseudo-random threshold between 4 and 11, and the result is written back. Each pre-synaptic spike produces an output spike that carries the slot's weight, both as a 4-bit value and as a pulse whose length in cycles equals the weight.

Top module: `stdp_tm_adaptor`

## Requirements
- R1: While reset is held, and for the two cycles after it is released, every output is 0. After reset every cached weight is 0 and every polarity bit is 0.
- R2: The LFSR is 8 bits wide, seeded with 0x01 when the internal reset is released, and shifts every cycle: next = {q[6:0], q[7]^q[5]^q[4]^q[3]}. A load (`ld_en`) writes {`ld_bit`, q[5:3]} into the weight of slot `ld_idx`.
- R3: A lone spike starts the window (`ws_en`, `ws_idx`) and leaves the weight unchanged when the window is inactive or was opened by the same spike type. It also sets polarity: 0 for pre, 1 for post.
- R4: A lone post spike in an active window with polarity 0 raises the weight by the step, saturating at 15.
- R5: A lone pre spike in an active window with polarity 1 lowers the weight by the step, saturating at 0.
- R6: The step is `win_cnt` when `win_cnt_ok` is 1 and 1 otherwise. A step of 0 leaves the weight unchanged.
- R7: Only an actual weight change raises `wb_en`. `wb_bit` is 1 exactly when the new weight exceeds 4 + q[2:0] of the LFSR in the serving cycle.
- R8: Each served pre spike raises `spk_vld` for one cycle, with `spk_idx` and `spk_weight`, where `spk_weight` is the weight before the update. All outputs are registered and appear one cycle after the serving edge.
- R9: `spk_pulse` is high for exactly `spk_weight` cycles, beginning with the `spk_vld` cycle. A later pre spike restarts it.
- R10: Pre and post together in one slot change neither the weight nor the window, but the output spike is still emitted.
- R11: When a load and a weight update hit the same slot in the same cycle, the loaded value wins.
- R12: When `slot_vld` is 0, the spike, window and count inputs have no effect on any output or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | 1 | A slot is served this cycle |
| slot_idx | input | 4 | Slot being served |
| pre_spk | input | 1 | Aligned pre-synaptic spike for the slot |
| post_spk | input | 1 | Aligned post-synaptic spike for the slot |
| win_active | input | 1 | Shared time window is active |
| win_cnt | input | 4 | Timer count of the window |
| win_cnt_ok | input | 1 | Count is valid (digital timer) |
| ld_en | input | 1 | Load a slot from master memory |
| ld_idx | input | 4 | Slot to load |
| ld_bit | input | 1 | Bistable bit read from master memory |
| wb_en | output | 1 | Write-back strobe to master memory |
| wb_idx | output | 4 | Slot of the write-back |
| wb_bit | output | 1 | Binarised weight to store |
| ws_en | output | 1 | Window start command |
| ws_idx | output | 4 | Slot whose window starts |
| spk_vld | output | 1 | Weighted pre-synaptic spike |
| spk_idx | output | 4 | Slot of the output spike |
| spk_weight | output | 4 | Weight carried by the spike |
| spk_pulse | output | 1 | Pulse-width coded weight |

## Verification
A wrong polarity bit does not stay hidden for long. The next paired spike on that slot turns an increase into a window restart, or the reverse, so `ws_en` and `wb_en` differ within one cycle of that slot's next service. A corrupted cached weight shows up on the next pre spike for that slot, both in `spk_weight` and in the pulse length. An LFSR out of step breaks the low bits of a loaded weight and the write-back bits. For that reason the bench follows the LFSR cycle by cycle from the release of reset, and it compares every output in every cycle against a queue of expectations.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
  typedef enum logic {POL_PRE = 1'b0, POL_POST = 1'b1} pol_e;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_START = 2'd1,
    ACT_INC   = 2'd2,
    ACT_DEC   = 2'd3
  } act_e;
endpackage

// File: rtl/stdp_lfsr.sv
module stdp_lfsr #(
  parameter int N = 8,
  parameter logic [N-1:0] TAPS = 8'hB8,
  parameter logic [N-1:0] SEED = 8'h01,
  parameter int THR_BITS = 3,
  parameter int FILL_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [THR_BITS-1:0]  thr_bits,
  output logic [FILL_BITS-1:0] fill_bits
);
  logic [N-1:0] q, q_d;

  always_comb begin
    q_d = {q[N-2:0], ^(q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= q_d;
  end

  assign thr_bits  = q[THR_BITS-1:0];
  assign fill_bits = q[THR_BITS+FILL_BITS-1:THR_BITS];
endmodule

// File: rtl/stdp_slot_mem.sv
module stdp_slot_mem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_din,
  input  logic             b_we,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_din,
  input  logic [AW-1:0]    r_addr,
  output logic [WIDTH-1:0] r_dout
);
  logic [DEPTH-1:0][WIDTH-1:0] rd_bank;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [WIDTH-1:0] ent_q, ent_d;
    logic             hit_a, hit_b, ent_en;

    always_comb begin
      hit_a  = a_we && (a_addr == AW'(i));
      hit_b  = b_we && (b_addr == AW'(i));
      ent_en = hit_a || hit_b;
      ent_d  = ent_q;
      if (hit_a) ent_d = a_din;
      if (hit_b) ent_d = b_din;   // port B has priority
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign rd_bank[i] = ent_q;
  end

  assign r_dout = rd_bank[r_addr];
endmodule

// File: rtl/stdp_rule.sv
module stdp_rule
  import stdp_pkg::*;
#(
  parameter int W_BITS = 4,
  parameter int CNT_BITS = 4
) (
  input  logic                pre_spk,
  input  logic                post_spk,
  input  logic                win_active,
  input  pol_e                pol,
  input  logic [CNT_BITS-1:0] win_cnt,
  input  logic                win_cnt_ok,
  input  logic [W_BITS-1:0]   w_cur,
  output act_e                act,
  output logic [W_BITS-1:0]   w_new,
  output logic                w_changed
);
  localparam int SUM_W = ((W_BITS > CNT_BITS) ? W_BITS : CNT_BITS) + 1;
  localparam logic [SUM_W-1:0] W_MAX = SUM_W'((1 << W_BITS) - 1);

  logic [SUM_W-1:0] delta, cur_ext, sum_up;

  always_comb begin
    delta   = win_cnt_ok ? SUM_W'(win_cnt) : SUM_W'(1);
    cur_ext = SUM_W'(w_cur);
    sum_up  = cur_ext + delta;

    act = ACT_NONE;
    if (pre_spk && !post_spk)
      act = (win_active && pol == POL_POST) ? ACT_DEC : ACT_START;
    else if (post_spk && !pre_spk)
      act = (win_active && pol == POL_PRE) ? ACT_INC : ACT_START;

    w_new = w_cur;
    case (act)
      ACT_INC: w_new = (sum_up > W_MAX) ? W_MAX[W_BITS-1:0] : sum_up[W_BITS-1:0];
      ACT_DEC: w_new = (delta >= cur_ext) ? '0 : W_BITS'(cur_ext - delta);
      default: w_new = w_cur;
    endcase
    w_changed = (w_new != w_cur);
  end
endmodule

// File: rtl/stdp_pulse_out.sv
module stdp_pulse_out #(
  parameter int W_BITS = 4,
  parameter bit PULSE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [W_BITS-1:0] w_in,
  output logic              pulse
);
  if (PULSE_EN) begin : g_pwm
    logic [W_BITS-1:0] cnt_q, cnt_d;
    logic              cnt_en;

    always_comb begin
      cnt_en = fire || (cnt_q != '0);
      cnt_d  = fire ? w_in : cnt_q - W_BITS'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign pulse = (cnt_q != '0);
  end else begin : g_none
    assign pulse = 1'b0;
  end
endmodule

// File: rtl/stdp_tm_adaptor.sv
module stdp_tm_adaptor
  import stdp_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int W_BITS = 4,
  parameter int CNT_BITS = 4,
  parameter int LFSR_BITS = 8,
  parameter logic [LFSR_BITS-1:0] LFSR_TAPS = 8'hB8,
  parameter bit PULSE_EN = 1'b1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_vld,
  input  logic [SLOT_W-1:0]   slot_idx,
  input  logic                pre_spk,
  input  logic                post_spk,
  input  logic                win_active,
  input  logic [CNT_BITS-1:0] win_cnt,
  input  logic                win_cnt_ok,
  input  logic                ld_en,
  input  logic [SLOT_W-1:0]   ld_idx,
  input  logic                ld_bit,
  output logic                wb_en,
  output logic [SLOT_W-1:0]   wb_idx,
  output logic                wb_bit,
  output logic                ws_en,
  output logic [SLOT_W-1:0]   ws_idx,
  output logic                spk_vld,
  output logic [SLOT_W-1:0]   spk_idx,
  output logic [W_BITS-1:0]   spk_weight,
  output logic                spk_pulse
);
  localparam int THR_BITS  = W_BITS - 1;
  localparam int FILL_BITS = W_BITS - 1;
  localparam int THR_BASE  = 1 << (W_BITS - 2);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  // random source
  logic [THR_BITS-1:0]  thr_bits;
  logic [FILL_BITS-1:0] fill_bits;
  stdp_lfsr #(
    .N(LFSR_BITS), .TAPS(LFSR_TAPS), .SEED(LFSR_BITS'(1)),
    .THR_BITS(THR_BITS), .FILL_BITS(FILL_BITS)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_core_n), .thr_bits(thr_bits), .fill_bits(fill_bits)
  );

  // per-slot state
  logic [W_BITS-1:0] w_rd, w_new;
  logic [0:0]        pol_rd;
  act_e              rule_act;
  logic              w_chg;
  logic              upd_we, pol_we;

  assign upd_we = slot_vld && w_chg;
  assign pol_we = slot_vld && (rule_act == ACT_START);

  stdp_slot_mem #(.DEPTH(NUM_SLOTS), .WIDTH(W_BITS)) u_wcache (
    .clk(clk), .rst_n(rst_core_n),
    .a_we(upd_we), .a_addr(slot_idx), .a_din(w_new),
    .b_we(ld_en), .b_addr(ld_idx), .b_din({ld_bit, fill_bits}),
    .r_addr(slot_idx), .r_dout(w_rd)
  );

  stdp_slot_mem #(.DEPTH(NUM_SLOTS), .WIDTH(1)) u_polmem (
    .clk(clk), .rst_n(rst_core_n),
    .a_we(pol_we), .a_addr(slot_idx), .a_din(post_spk),
    .b_we(1'b0), .b_addr('0), .b_din(1'b0),
    .r_addr(slot_idx), .r_dout(pol_rd)
  );

  stdp_rule #(.W_BITS(W_BITS), .CNT_BITS(CNT_BITS)) u_rule (
    .pre_spk(pre_spk), .post_spk(post_spk), .win_active(win_active),
    .pol(pol_e'(pol_rd)), .win_cnt(win_cnt), .win_cnt_ok(win_cnt_ok),
    .w_cur(w_rd), .act(rule_act), .w_new(w_new), .w_changed(w_chg)
  );

  // output stage: next-state
  logic [W_BITS-1:0] threshold;
  logic spk_d, wb_d, ws_d, wbb_d;
  always_comb begin
    threshold = W_BITS'(THR_BASE) + W_BITS'(thr_bits);
    spk_d = slot_vld && pre_spk;
    wb_d  = upd_we;
    ws_d  = pol_we;
    wbb_d = (w_new > threshold);
  end

  // output stage: registers
  logic                spk_q, wb_q, ws_q, wbb_q;
  logic [SLOT_W-1:0]   idx_q;
  logic [W_BITS-1:0]   sw_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      spk_q <= 1'b0;
      wb_q  <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      spk_q <= spk_d;
      wb_q  <= wb_d;
      ws_q  <= ws_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) idx_q <= '0;
    else if (slot_vld) idx_q <= slot_idx;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) sw_q <= '0;
    else if (spk_d)  sw_q <= w_rd;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) wbb_q <= 1'b0;
    else if (wb_d)   wbb_q <= wbb_d;
  end

  stdp_pulse_out #(.W_BITS(W_BITS), .PULSE_EN(PULSE_EN)) u_pulse (
    .clk(clk), .rst_n(rst_core_n), .fire(spk_d), .w_in(w_rd), .pulse(spk_pulse)
  );

  assign spk_vld    = spk_q;
  assign spk_idx    = idx_q;
  assign spk_weight = spk_q ? sw_q : '0;
  assign wb_en      = wb_q;
  assign wb_idx     = idx_q;
  assign wb_bit     = wb_q & wbb_q;
  assign ws_en      = ws_q;
  assign ws_idx     = idx_q;
endmodule

// File: rtl/stdp_tm_adaptor_chk.sv
module stdp_tm_adaptor_chk #(
  parameter int W_BITS = 4
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              slot_vld,
  input logic              pre_spk,
  input logic              post_spk,
  input logic              win_active,
  input logic              spk_vld,
  input logic              wb_en,
  input logic              ws_en,
  input logic              spk_pulse,
  input logic [W_BITS-1:0] spk_weight
);
  // R8
  spk_follows_pre_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    slot_vld && pre_spk |=> spk_vld);

  // R8
  spk_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    spk_vld |-> $past(slot_vld && pre_spk));

  // R7
  wb_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    wb_en |-> $past(slot_vld && win_active && (pre_spk != post_spk)));

  // R3
  start_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ws_en |-> !wb_en);

  // R10
  both_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    slot_vld && pre_spk && post_spk |=> !ws_en && !wb_en);

  // R9
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(spk_pulse) |-> spk_vld && (spk_weight != '0));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !slot_vld |=> !spk_vld && !wb_en && !ws_en);
endmodule

bind stdp_tm_adaptor stdp_tm_adaptor_chk #(.W_BITS(W_BITS)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .slot_vld(slot_vld), .pre_spk(pre_spk),
  .post_spk(post_spk), .win_active(win_active), .spk_vld(spk_vld),
  .wb_en(wb_en), .ws_en(ws_en), .spk_pulse(spk_pulse), .spk_weight(spk_weight)
);

// File: tb/tb_stdp_tm_adaptor.sv
`timescale 1ns/1ps
module tb_stdp_tm_adaptor;
  localparam int NS = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n;
  logic slot_vld, pre_spk, post_spk, win_active, win_cnt_ok, ld_en, ld_bit;
  logic [SW-1:0] slot_idx, ld_idx;
  logic [3:0] win_cnt;
  logic wb_en, wb_bit, ws_en, spk_vld, spk_pulse;
  logic [SW-1:0] wb_idx, ws_idx, spk_idx;
  logic [3:0] spk_weight;

  stdp_tm_adaptor dut (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_idx(slot_idx),
    .pre_spk(pre_spk), .post_spk(post_spk), .win_active(win_active),
    .win_cnt(win_cnt), .win_cnt_ok(win_cnt_ok), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_bit(ld_bit), .wb_en(wb_en), .wb_idx(wb_idx), .wb_bit(wb_bit),
    .ws_en(ws_en), .ws_idx(ws_idx), .spk_vld(spk_vld), .spk_idx(spk_idx),
    .spk_weight(spk_weight), .spk_pulse(spk_pulse)
  );

  typedef struct {
    bit spk; bit wb; bit wbb; bit ws; bit pulse;
    int sidx; int sw; string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state built from the requirements
  int mw[NS];
  bit mp[NS];
  int pm = 0;
  logic b1, b2;
  logic [7:0] ml;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin b1 <= 1'b0; b2 <= 1'b0; end
    else begin b1 <= 1'b1; b2 <= b1; end

  always @(posedge clk or negedge b2)
    if (!b2) ml <= 8'h01;
    else     ml <= {ml[6:0], ml[7] ^ ml[5] ^ ml[4] ^ ml[3]};

  task automatic check(bit ok, string tag, string what, int a, int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, a, e);
    end
  endtask

  task automatic cyc(bit sv, int idx, bit pre, bit post, bit act, int cnt, bit cok,
                     bit le, int lidx, bit lb, string tag);
    exp_t e;
    int w, neww, delta, thr, fill;
    bit start;
    @(negedge clk);
    slot_vld = sv; slot_idx = SW'(idx); pre_spk = pre; post_spk = post;
    win_active = act; win_cnt = 4'(cnt); win_cnt_ok = cok;
    ld_en = le; ld_idx = SW'(lidx); ld_bit = lb;
    e.spk = 0; e.wb = 0; e.wbb = 0; e.ws = 0; e.sidx = idx; e.sw = 0; e.tag = tag;
    thr  = 4 + int'(ml[2:0]);
    fill = int'(ml[5:3]);
    w = mw[idx];
    if (sv) begin
      e.spk = pre; e.sw = w;
      delta = cok ? cnt : 1;
      neww = w; start = 0;
      if (pre && !post) begin
        if (act && mp[idx]) neww = (w - delta < 0) ? 0 : w - delta;
        else start = 1;
      end else if (post && !pre) begin
        if (act && !mp[idx]) neww = (w + delta > 15) ? 15 : w + delta;
        else start = 1;
      end
      if (neww != w) begin e.wb = 1; e.wbb = (neww > thr); mw[idx] = neww; end
      if (start) begin e.ws = 1; mp[idx] = post; end
    end
    if (le) mw[lidx] = (lb ? 8 : 0) + fill;
    if (sv && pre) pm = w;
    else if (pm > 0) pm--;
    e.pulse = (pm != 0);
    q.push_back(e);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(spk_vld == e.spk, e.tag, "spk_vld", int'(spk_vld), int'(e.spk));
        if (e.spk) begin
          check(int'(spk_idx) == e.sidx, e.tag, "spk_idx", int'(spk_idx), e.sidx);
          check(int'(spk_weight) == e.sw, e.tag, "spk_weight", int'(spk_weight), e.sw);
        end
        check(wb_en == e.wb, e.tag, "wb_en", int'(wb_en), int'(e.wb));
        if (e.wb) begin
          check(int'(wb_idx) == e.sidx, e.tag, "wb_idx", int'(wb_idx), e.sidx);
          check(wb_bit == e.wbb, e.tag, "wb_bit", int'(wb_bit), int'(e.wbb));
        end
        check(ws_en == e.ws, e.tag, "ws_en", int'(ws_en), int'(e.ws));
        if (e.ws) check(int'(ws_idx) == e.sidx, e.tag, "ws_idx", int'(ws_idx), e.sidx);
        check(spk_pulse == e.pulse, e.tag, "spk_pulse", int'(spk_pulse), int'(e.pulse));
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin mw[i] = 0; mp[i] = 0; end
    rst_n = 1'b0;
    slot_vld = 0; slot_idx = '0; pre_spk = 0; post_spk = 0; win_active = 0;
    win_cnt = '0; win_cnt_ok = 0; ld_en = 0; ld_idx = '0; ld_bit = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset, even with stimulus applied
    slot_vld = 1; pre_spk = 1;
    @(negedge clk);
    check(!spk_vld && !wb_en && !ws_en && !spk_pulse && spk_weight == 0,
          "R1", "outputs in reset", int'({spk_vld, wb_en, ws_en, spk_pulse}), 0);
    slot_vld = 0; pre_spk = 0;
    rst_n = 1'b1;
    idle(3, "R1 release");

    // R1/R3: fresh slot shows weight 0 and opens a pre window
    cyc(1, 3, 1, 0, 0, 0, 0, 0, 0, 0, "R3 pre opens window");
    cyc(1, 3, 0, 1, 1, 0, 0, 0, 0, 0, "R4 post in pre window, unit step");
    cyc(1, 3, 0, 1, 1, 0, 0, 0, 0, 0, "R4 second increase");
    cyc(1, 3, 1, 0, 0, 0, 0, 0, 0, 0, "R8 spike carries weight 2");
    // R2: load expands the bistable bit
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5, 1, "R2 load bit 1");
    cyc(1, 5, 1, 0, 0, 0, 0, 0, 0, 0, "R2 loaded weight on spike");
    cyc(1, 5, 0, 1, 1, 9, 1, 0, 0, 0, "R6 count step");
    cyc(1, 5, 0, 1, 1, 3, 1, 0, 0, 0, "R4 saturate at 15");
    cyc(1, 5, 1, 0, 1, 2, 1, 0, 0, 0, "R3 same type restarts");
    cyc(1, 5, 0, 1, 0, 0, 0, 0, 0, 0, "R3 post opens window");
    cyc(1, 5, 1, 0, 1, 6, 1, 0, 0, 0, "R5 pre in post window");
    cyc(1, 5, 1, 0, 1, 0, 1, 0, 0, 0, "R6 zero count no change");
    cyc(1, 5, 1, 0, 1, 12, 1, 0, 0, 0, "R5 saturate at 0");
    cyc(1, 5, 1, 0, 1, 2, 1, 0, 0, 0, "R5 floor stays 0");
    cyc(1, 5, 1, 1, 1, 4, 1, 0, 0, 0, "R10 simultaneous spikes");
    cyc(0, 5, 1, 1, 1, 4, 1, 0, 0, 0, "R12 idle slot ignored");
    cyc(0, 5, 0, 1, 1, 4, 0, 0, 0, 0, "R12 idle slot ignored");
    cyc(1, 5, 0, 1, 1, 1, 0, 0, 0, 0, "R12 state kept");
    // R11: load and update collide
    cyc(1, 9, 1, 0, 0, 0, 0, 0, 0, 0, "R11 set window");
    cyc(1, 9, 0, 1, 1, 5, 1, 1, 9, 0, "R11 load wins");
    cyc(1, 9, 1, 0, 0, 0, 0, 0, 0, 0, "R11 readback");
    // R9: pulse length and restart
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 7, 1, "R9 load");
    cyc(1, 7, 1, 0, 0, 0, 0, 0, 0, 0, "R9 first pulse");
    idle(3, "R9 pulse running");
    cyc(1, 7, 1, 0, 0, 0, 0, 0, 0, 0, "R9 restart");
    idle(18, "R9 pulse drain");
    // R7 and mixed traffic
    for (int k = 0; k < 400; k++) begin
      bit sv, pre, post, le;
      sv = ($urandom % 4) != 0;
      pre = $urandom % 2; post = $urandom % 2;
      le = ($urandom % 6) == 0;
      cyc(sv, $urandom % NS, pre, post, $urandom % 2, $urandom % 16, $urandom % 2,
          le, $urandom % NS, $urandom % 2, "R7 mixed traffic");
    end
    idle(20, "R9 final drain");
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule